// File: doc/BRIEF.md
# Packed Signed Lane Adder with Greater-or-Equal Flags

This block adds two 32-bit words as a set of independent signed lanes. A one-bit mode input picks the lane layout: four byte lanes or two halfword lanes. Each lane pair is sign-extended and added one bit wider than the lane, so the true sum is always known. The lane result keeps only the low bits of that sum and wraps when the sum is out of range. One greater-or-equal flag per byte position records whether the true sum was zero or positive.

A pipeline presents operands, the mode and a valid strobe. One clock later the block returns the packed result, the four flags and a matching valid strobe. The outputs keep their values until another valid input arrives. No other condition flag is computed.

Top module: `packed_sadd_ge`

## Requirements
- R1: With `mode`=0 (byte lanes), result bits 8i+7..8i equal the low 8 bits of the signed sum of operand bits 8i+7..8i, for i = 0..3.
- R2: With `mode`=0, `ge[i]` is 1 exactly when the signed 9-bit sum of byte lane i is greater than or equal to zero.
- R3: With `mode`=1 (halfword lanes), result bits 16i+15..16i equal the low 16 bits of the signed sum of operand bits 16i+15..16i, for i = 0..1.
- R4: With `mode`=1, `ge[2i]` and `ge[2i+1]` are both 1 when the signed 17-bit sum of halfword lane i is nonnegative, and both 0 when it is negative.
- R5: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1, and result and flags for that input appear together with it.
- R6: A clock edge with `in_valid`=0 leaves `result` and `ge` unchanged, whatever the operands and mode are.
- R7: A clock edge with `rst`=1 clears `result`, `ge` and `out_valid` to zero.
- R8: In byte mode, 0x80 plus 0x80 gives lane result 0x00 with its flag clear, and 0x7F plus 0x01 gives 0x80 with its flag set.
- R9: A carry out of one lane never changes a neighbouring lane (for example 0xFF plus 0x01 in byte lane 0 leaves byte lane 1 at its own sum).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| mode | input | 1 | Lane layout: 0 four byte lanes, 1 two halfword lanes |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand |
| out_valid | output | 1 | Result and flags from the previous cycle's input |
| result | output | 32 | Packed wrapped lane sums |
| ge | output | 4 | Greater-or-equal flags, one per byte position |

## Verification
Any fault in the lane adders or the flag expander shows at the ports one clock after the offending input, as a wrong result lane or a flag that disagrees with the sign of the true sum; a carry leaking across a lane edge shows as an off-by-one in the upper lane. A fault in the output register shows as a valid strobe out of step with its input, or as results that drift while no input is valid. The sweep covers every byte value pair in every byte lane, so a sign-extension or flag error on any single value pair is reported in the cycle after that pair.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  typedef enum logic {
    LANES_BYTE = 1'b0,
    LANES_HALF = 1'b1
  } lane_mode_e;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned WIDE_W   = 16;

endpackage

// File: rtl/sadd_lane.sv
module sadd_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         nonneg
);

  // Sign-extend both operands by one bit and add: the W+1 bit sum is exact.
  function automatic logic [W:0] widened_add(input logic [W-1:0] x,
                                              input logic [W-1:0] y);
    logic signed [W:0] xs;
    logic signed [W:0] ys;
    xs = $signed({x[W-1], x});
    ys = $signed({y[W-1], y});
    return xs + ys;
  endfunction

  logic [W:0] exact_sum;

  assign exact_sum = widened_add(a, b);
  assign sum       = exact_sum[W-1:0];
  assign nonneg    = ~exact_sum[W];

endmodule

// File: rtl/sadd_flag_expand.sv
module sadd_flag_expand
  import simd_add_pkg::*;
#(
  parameter int unsigned N_NARROW = 4,
  parameter int unsigned N_WIDE   = 2
) (
  input  lane_mode_e          mode,
  input  logic [N_NARROW-1:0] narrow_nonneg,
  input  logic [N_WIDE-1:0]   wide_nonneg,
  output logic [N_NARROW-1:0] ge_flags
);

  localparam int unsigned SPAN = N_NARROW / N_WIDE;

  for (genvar k = 0; k < N_NARROW; k++) begin : g_flag
    assign ge_flags[k] = (mode == LANES_HALF) ? wide_nonneg[k / SPAN]
                                              : narrow_nonneg[k];
  end

endmodule

// File: rtl/sadd_out_reg.sv
module sadd_out_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] res_d,
  input  logic [FLAG_W-1:0] flag_d,
  output logic              vld_q,
  output logic [DATA_W-1:0] res_q,
  output logic [FLAG_W-1:0] flag_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      flag_q <= '0;
    end else begin
      vld_q <= load;
      if (load) begin
        res_q  <= res_d;
        flag_q <= flag_d;
      end
    end
  end

endmodule

// File: rtl/packed_sadd_ge.sv
module packed_sadd_ge
  import simd_add_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned BYTE_W = NARROW_W,
  parameter int unsigned HALF_W = WIDE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       mode,
  input  logic [DATA_W-1:0]          op_a,
  input  logic [DATA_W-1:0]          op_b,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          result,
  output logic [DATA_W/BYTE_W-1:0]   ge
);

  localparam int unsigned NB = DATA_W / BYTE_W;
  localparam int unsigned NH = DATA_W / HALF_W;

  lane_mode_e        lane_mode;
  logic [DATA_W-1:0] byte_sum;
  logic [DATA_W-1:0] half_sum;
  logic [NB-1:0]     byte_nonneg;
  logic [NH-1:0]     half_nonneg;
  logic [DATA_W-1:0] res_next;
  logic [NB-1:0]     ge_next;

  assign lane_mode = lane_mode_e'(mode);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    sadd_lane #(.W(BYTE_W)) u_lane (
      .a      (op_a[i*BYTE_W +: BYTE_W]),
      .b      (op_b[i*BYTE_W +: BYTE_W]),
      .sum    (byte_sum[i*BYTE_W +: BYTE_W]),
      .nonneg (byte_nonneg[i])
    );
  end

  for (genvar j = 0; j < NH; j++) begin : g_half
    sadd_lane #(.W(HALF_W)) u_lane (
      .a      (op_a[j*HALF_W +: HALF_W]),
      .b      (op_b[j*HALF_W +: HALF_W]),
      .sum    (half_sum[j*HALF_W +: HALF_W]),
      .nonneg (half_nonneg[j])
    );
  end

  assign res_next = (lane_mode == LANES_HALF) ? half_sum : byte_sum;

  sadd_flag_expand #(.N_NARROW(NB), .N_WIDE(NH)) u_flags (
    .mode          (lane_mode),
    .narrow_nonneg (byte_nonneg),
    .wide_nonneg   (half_nonneg),
    .ge_flags      (ge_next)
  );

  sadd_out_reg #(.DATA_W(DATA_W), .FLAG_W(NB)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .load   (in_valid),
    .res_d  (res_next),
    .flag_d (ge_next),
    .vld_q  (out_valid),
    .res_q  (result),
    .flag_q (ge)
  );

endmodule

// File: rtl/packed_sadd_ge_chk.sv
module packed_sadd_ge_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NB     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              mode,
  input logic [NB-1:0]     byte_nonneg,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [NB-1:0]     ge
);

  // R5: output strobe tracks the input strobe one cycle later
  p_valid_follow_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R6: no valid input, no change
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(ge)));

  // R4: halfword flags come in equal pairs
  p_pair_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode) |=> ((ge[1] == ge[0]) && (ge[3] == ge[2])));

  // R2: registered byte flags equal the lane sign decisions
  p_byte_flags_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode) |=> (ge == $past(byte_nonneg)));

  // R7: reset clears every output register
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!out_valid && (result == '0) && (ge == '0)));

endmodule

bind packed_sadd_ge packed_sadd_ge_chk #(.DATA_W(DATA_W), .NB(NB)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .mode        (mode),
  .byte_nonneg (byte_nonneg),
  .out_valid   (out_valid),
  .result      (result),
  .ge          (ge)
);

// File: tb/packed_sadd_ge_test.sv
module packed_sadd_ge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  ge;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  packed_sadd_ge uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .result(result), .ge(ge)
  );

  // Reference model written with plain integers.
  function automatic int as_signed(input int v, input int bits);
    int half = 1 << (bits - 1);
    return (v >= half) ? v - (1 << bits) : v;
  endfunction

  function automatic void model(input bit m, input logic [31:0] a,
                                input logic [31:0] b,
                                output logic [31:0] r, output logic [3:0] g);
    int lw = m ? 16 : 8;
    int nl = 32 / lw;
    r = '0;
    g = '0;
    for (int i = 0; i < nl; i++) begin
      int mask = (1 << lw) - 1;
      int x = as_signed(int'((a >> (i * lw))) & mask, lw);
      int y = as_signed(int'((b >> (i * lw))) & mask, lw);
      int s = x + y;
      r = r | (32'(s & mask) << (i * lw));
      if (s >= 0) begin
        if (m) g = g | (4'b0011 << (2 * i));
        else   g = g | (4'b0001 << i);
      end
    end
  endfunction

  task automatic check32(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input bit m, input logic [31:0] a,
                       input logic [31:0] b,
                       input string rtag, input string gtag);
    logic [31:0] er;
    logic [3:0]  eg;
    model(m, a, b, er, eg);
    @(negedge clk);
    in_valid = 1'b1;
    mode = m;
    op_a = a;
    op_b = b;
    @(posedge clk);
    #1;
    check32(rtag, result, er);
    check32(gtag, {28'd0, ge}, {28'd0, eg});
    check32("R5 valid", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_r;
    logic [3:0]  held_g;
    repeat (3) @(posedge clk);
    #1;
    check32("R7 reset result", result, 32'd0);
    check32("R7 reset ge", {28'd0, ge}, 32'd0);
    check32("R7 reset valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R8 corner lanes, R9 carry isolation
    apply(1'b0, 32'h7F7F_8080, 32'h0101_8080, "R8 result", "R8 ge");
    check32("R8 lane0", result & 32'hFF, 32'h00);
    check32("R8 ge0", {31'd0, ge[0]}, 32'd0);
    check32("R8 lane3", result >> 24, 32'h80);
    check32("R8 ge3", {31'd0, ge[3]}, 32'd1);
    apply(1'b0, 32'h0000_00FF, 32'h0000_0001, "R9 result", "R9 ge");
    check32("R9 lane1 untouched", result & 32'hFF00, 32'h0);
    apply(1'b1, 32'h0000_FFFF, 32'h0000_0001, "R9 half result", "R9 half ge");
    check32("R9 half lane1 untouched", result >> 16, 32'h0);
    apply(1'b1, 32'h7FFF_8000, 32'h0001_8000, "R3 edge result", "R4 edge ge");

    // R6: valid low, change operands and mode, outputs must hold
    held_r = result;
    held_g = ge;
    @(negedge clk);
    in_valid = 1'b0;
    op_a = 32'hDEAD_BEEF;
    op_b = 32'h1234_5678;
    mode = 1'b0;
    @(posedge clk);
    #1;
    check32("R5 valid drop", {31'd0, out_valid}, 32'd0);
    @(posedge clk);
    #1;
    check32("R6 result held", result, held_r);
    check32("R6 ge held", {28'd0, ge}, {28'd0, held_g});

    // Byte mode: every value pair in every lane (R1, R2)
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        logic [7:0] xb = 8'(x);
        logic [7:0] yb = 8'(y);
        apply(1'b0, {xb + 8'd3, yb, ~xb, xb}, {yb + 8'd7, xb, yb, yb},
              "R1 byte result", "R2 byte ge");
      end
    end

    // Halfword mode spread sweep (R3, R4)
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] a = 32'(i) * 32'h9E37_79B1;
      logic [31:0] b = 32'(i) * 32'h7F4A_7C15 + 32'h8000_0001;
      apply(1'b1, a, b, "R3 half result", "R4 half ge");
    end

    // R7: reset mid-run clears
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    check32("R7 mid reset result", result, 32'd0);
    check32("R7 mid reset valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end

endmodule